// File: doc/BRIEF.md
# Selectable-Function Four-Input Blocking Gate

This block is a small programmable logic gate that combines four logic inputs under one of five selectable functions: OR, AND, NOR, NAND, or an off state. The gate has one assigned setting group and only acts while that group is the active one. When the gate is off, or its group is not active, its output is held low.

The same block serves two uses. As a general logic gate, its registered output feeds other logic. As a blocking gate, the registered output masks the trip signal of one protection element. The element's pickup indication passes through unchanged, so the element still shows pickup but cannot trip while it is blocked.

A parameter picks the use. It sets the function held after reset: OR for a general gate, off for a blocking gate. A single configuration strobe loads a new function code and a new group.

Top module: `blkg_top`

## Requirements
- R1: After reset, `gate_out` is 0, the stored group is group 1 (code 0), and the stored function is the per-instance default.
- R2: Function codes on `cfg_func`: 0 = Disable, 1 = OR, 2 = AND, 3 = NOR, 4 = NAND. The chosen function is applied across all four bits of `gate_in`.
- R3: Codes 5, 6 and 7 behave exactly like Disable.
- R4: While the stored function is Disable, `gate_out` is 0 on the following cycle, whatever the inputs are.
- R5: The gate evaluates only when the stored group code (0..3 for groups 1..4) equals `act_group`. On a mismatch, `gate_out` is 0 on the following cycle.
- R6: `gate_out` is registered. A change in `gate_in`, `act_group` or the stored configuration shows on `gate_out` one clock edge after it is seen.
- R7: A clock edge with `cfg_wr` high loads `cfg_func` and `cfg_group`. While `cfg_wr` is low, these inputs have no effect.
- R8: `trip_out` equals `raw_trip` AND NOT `gate_out`, with no added delay.
- R9: `pickup_out` always equals `raw_pickup`, including while the gate blocks.
- R10: When `BLOCKING_USE` = 1, the reset function is Disable. When it is 0, the reset function is OR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Strobe that loads the function and group fields |
| cfg_func | input | 3 | Function code to load |
| cfg_group | input | 2 | Setting group to load, as group minus one |
| act_group | input | 2 | Currently active setting group, as group minus one |
| gate_in | input | N_IN (4) | Logic inputs of the gate |
| raw_trip | input | 1 | Unmasked trip from the protection element |
| raw_pickup | input | 1 | Pickup indication from the protection element |
| gate_out | output | 1 | Registered gate output, which is the block signal |
| trip_out | output | 1 | Trip after masking by the gate output |
| pickup_out | output | 1 | Pickup passed through unchanged |

## Verification
A raw trip can arrive in the same cycle as the inputs that will make the gate block. Because the block signal is registered, the trip passes in that cycle and is masked only from the next clock edge on. The bench raises `raw_trip` together with a blocking input pattern. It checks that `trip_out` is high before the edge and low after it, and that `pickup_out` stays high throughout. A second collision the bench covers is a configuration write in the same cycle as an input change: it checks that the output first reflects the old function and then the new one.

// File: rtl/blkg_pkg.sv
package blkg_pkg;

  typedef enum logic [2:0] {
    FN_DISABLE = 3'd0,
    FN_OR      = 3'd1,
    FN_AND     = 3'd2,
    FN_NOR     = 3'd3,
    FN_NAND    = 3'd4
  } gate_fn_e;

  localparam int FN_W  = 3;
  localparam int GRP_W = 2;

  // Evaluate the selected function from the two reductions of the inputs.
  function automatic logic eval_gate(input logic [FN_W-1:0] fn,
                                     input logic any_hi,
                                     input logic all_hi);
    logic r;
    case (fn)
      FN_OR:   r = any_hi;
      FN_AND:  r = all_hi;
      FN_NOR:  r = ~any_hi;
      FN_NAND: r = ~all_hi;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/blkg_cfg_reg.sv
module blkg_cfg_reg
  import blkg_pkg::*;
#(
  parameter logic [FN_W-1:0]  DEF_FUNC  = FN_OR,
  parameter logic [GRP_W-1:0] DEF_GROUP = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [FN_W-1:0]  func_d,
  input  logic [GRP_W-1:0] grp_d,
  output logic [FN_W-1:0]  func_q,
  output logic [GRP_W-1:0] grp_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q <= DEF_FUNC;
      grp_q  <= DEF_GROUP;
    end else if (wr) begin
      func_q <= func_d;
      grp_q  <= grp_d;
    end
  end

endmodule

// File: rtl/blkg_logic_core.sv
module blkg_logic_core
  import blkg_pkg::*;
#(
  parameter int N_IN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FN_W-1:0]  func_q,
  input  logic [GRP_W-1:0] grp_q,
  input  logic [GRP_W-1:0] act_group,
  input  logic [N_IN-1:0]  gate_in,
  output logic             any_hi,
  output logic             all_hi,
  output logic             grp_hit,
  output logic             gate_q
);

  logic gate_d;

  assign any_hi  = |gate_in;
  assign all_hi  = &gate_in;
  assign grp_hit = (grp_q == act_group);
  assign gate_d  = grp_hit & eval_gate(func_q, any_hi, all_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_d;
  end

endmodule

// File: rtl/blkg_trip_mask.sv
module blkg_trip_mask (
  input  logic block,
  input  logic raw_trip,
  input  logic raw_pickup,
  output logic trip_out,
  output logic pickup_out
);

  assign trip_out   = raw_trip & ~block;
  assign pickup_out = raw_pickup;

endmodule

// File: rtl/blkg_top.sv
module blkg_top
  import blkg_pkg::*;
#(
  parameter int N_IN         = 4,
  parameter bit BLOCKING_USE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_func,
  input  logic [1:0]       cfg_group,
  input  logic [1:0]       act_group,
  input  logic [N_IN-1:0]  gate_in,
  input  logic             raw_trip,
  input  logic             raw_pickup,
  output logic             gate_out,
  output logic             trip_out,
  output logic             pickup_out
);

  localparam logic [FN_W-1:0] DEF_FUNC = BLOCKING_USE ? FN_DISABLE : FN_OR;

  logic [FN_W-1:0]  func_q;
  logic [GRP_W-1:0] grp_q;
  logic             any_hi;
  logic             all_hi;
  logic             grp_hit;

  blkg_cfg_reg #(.DEF_FUNC(DEF_FUNC), .DEF_GROUP('0)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr),
    .func_d(cfg_func), .grp_d(cfg_group),
    .func_q(func_q), .grp_q(grp_q)
  );

  blkg_logic_core #(.N_IN(N_IN)) u_core (
    .clk(clk), .rst_n(rst_n), .func_q(func_q), .grp_q(grp_q),
    .act_group(act_group), .gate_in(gate_in),
    .any_hi(any_hi), .all_hi(all_hi), .grp_hit(grp_hit), .gate_q(gate_out)
  );

  blkg_trip_mask u_mask (
    .block(gate_out), .raw_trip(raw_trip), .raw_pickup(raw_pickup),
    .trip_out(trip_out), .pickup_out(pickup_out)
  );

endmodule

// File: rtl/blkg_top_chk.sv
module blkg_top_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] func_q,
  input logic       grp_hit,
  input logic       any_hi,
  input logic       all_hi,
  input logic       gate_out,
  input logic       raw_trip,
  input logic       trip_out,
  input logic       raw_pickup,
  input logic       pickup_out
);

  // R3 R4 R5: an off function or a group mismatch forces the output low
  a_r4_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!grp_hit || func_q == 3'd0 || func_q > 3'd4) |=> !gate_out);

  // R2 R6: OR follows the inputs one edge later
  a_r2_or_func: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_hit && func_q == 3'd1) |=> (gate_out == $past(any_hi)));

  // R2 R6: NAND follows the inputs one edge later
  a_r2_nand_func: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_hit && func_q == 3'd4) |=> (gate_out == !$past(all_hi)));

  // R8: a block suppresses the trip
  a_r8_trip_masked: assert property (@(posedge clk) disable iff (!rst_n)
    gate_out |-> !trip_out);

  // R8: with no block the trip passes
  a_r8_trip_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_out && raw_trip) |-> trip_out);

  // R9: pickup is never altered
  a_r9_pickup_thru: assert property (@(posedge clk) disable iff (!rst_n)
    pickup_out == raw_pickup);

endmodule

bind blkg_top blkg_top_chk u_chk (
  .clk(clk), .rst_n(rst_n), .func_q(func_q), .grp_hit(grp_hit),
  .any_hi(any_hi), .all_hi(all_hi), .gate_out(gate_out),
  .raw_trip(raw_trip), .trip_out(trip_out),
  .raw_pickup(raw_pickup), .pickup_out(pickup_out)
);

// File: tb/blkg_top_tb.sv
`timescale 1ns/1ps
module blkg_top_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_func = 3'd0;
  logic [1:0] cfg_group = 2'd0;
  logic [1:0] act_group = 2'd0;
  logic [3:0] gate_in = 4'd0;
  logic       raw_trip = 1'b0;
  logic       raw_pickup = 1'b0;
  logic       gate_out, trip_out, pickup_out;
  logic       gp_gate, gp_trip, gp_pick;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  blkg_top #(.N_IN(4), .BLOCKING_USE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_func(cfg_func),
    .cfg_group(cfg_group), .act_group(act_group), .gate_in(gate_in),
    .raw_trip(raw_trip), .raw_pickup(raw_pickup),
    .gate_out(gate_out), .trip_out(trip_out), .pickup_out(pickup_out)
  );

  blkg_top #(.N_IN(4), .BLOCKING_USE(1'b0)) u_dut_gp (
    .clk(clk), .rst_n(rst_n), .cfg_wr(1'b0), .cfg_func(cfg_func),
    .cfg_group(cfg_group), .act_group(act_group), .gate_in(gate_in),
    .raw_trip(raw_trip), .raw_pickup(raw_pickup),
    .gate_out(gp_gate), .trip_out(gp_trip), .pickup_out(gp_pick)
  );

  // {func[7:5], inputs[4:1], expected[0]}
  localparam logic [7:0] VEC [14] = '{
    {3'd1, 4'b0000, 1'b0}, {3'd1, 4'b0100, 1'b1},
    {3'd2, 4'b1111, 1'b1}, {3'd2, 4'b1110, 1'b0},
    {3'd3, 4'b0000, 1'b1}, {3'd3, 4'b1000, 1'b0},
    {3'd4, 4'b1111, 1'b0}, {3'd4, 4'b0111, 1'b1},
    {3'd0, 4'b1111, 1'b0}, {3'd0, 4'b0000, 1'b0},
    {3'd5, 4'b1111, 1'b0}, {3'd6, 4'b0000, 1'b0},
    {3'd7, 4'b1010, 1'b0}, {3'd2, 4'b0001, 1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic load_cfg(input logic [2:0] f, input logic [1:0] g);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_func = f; cfg_group = g;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset output", gate_out, 1'b0);
    rst_n = 1'b1;
    // R1 R10: defaults, group 1 active, all inputs high
    gate_in = 4'b1111; act_group = 2'd0;
    @(negedge clk);
    chk("R10 blocking default Disable", gate_out, 1'b0);
    chk("R10 general default OR", gp_gate, 1'b1);
    act_group = 2'd1;
    @(negedge clk);
    chk("R1 default group is 1", gp_gate, 1'b0);
    act_group = 2'd0;

    // R2 R3 R4: vector table
    foreach (VEC[i]) begin
      load_cfg(VEC[i][7:5], 2'd0);
      gate_in = VEC[i][4:1];
      @(negedge clk);
      chk($sformatf("R2/R3/R4 vec %0d", i), gate_out, VEC[i][0]);
    end

    // R5: group mismatch then match
    load_cfg(3'd1, 2'd2);
    gate_in = 4'b0010; act_group = 2'd0;
    @(negedge clk);
    chk("R5 group mismatch low", gate_out, 1'b0);
    act_group = 2'd2;
    @(negedge clk);
    chk("R5 group match evaluates", gate_out, 1'b1);

    // R7: fields ignored without strobe
    cfg_func = 3'd0; cfg_group = 2'd3;
    @(negedge clk); @(negedge clk);
    chk("R7 no strobe no change", gate_out, 1'b1);

    // R6: one edge latency on input change
    gate_in = 4'b0000;
    #1;
    chk("R6 old value before edge", gate_out, 1'b1);
    @(negedge clk);
    chk("R6 new value after edge", gate_out, 1'b0);

    // R6 R7: config write in same cycle as input change (OR -> NOR)
    cfg_wr = 1'b1; cfg_func = 3'd3; cfg_group = 2'd2; gate_in = 4'b0001;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk("R6 old function first", gate_out, 1'b1);
    @(negedge clk);
    chk("R7 new function next", gate_out, 1'b0);

    // R8 R9: trip arriving with blocking inputs (NOR, inputs to 0 => block)
    raw_trip = 1'b1; raw_pickup = 1'b1; gate_in = 4'b0000;
    #1;
    chk("R8 trip passes before block edge", trip_out, 1'b1);
    chk("R9 pickup before block", pickup_out, 1'b1);
    @(negedge clk);
    chk("R8 block registered", gate_out, 1'b1);
    chk("R8 trip masked", trip_out, 1'b0);
    chk("R9 pickup while blocked", pickup_out, 1'b1);
    raw_pickup = 1'b0;
    #1;
    chk("R9 pickup low follows", pickup_out, 1'b0);
    gate_in = 4'b0100;
    @(negedge clk);
    chk("R8 trip released", trip_out, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule